// File: doc/BRIEF.md
# Asymmetric Range Barrel Shifter

This block shifts a 40-bit operand by a signed count in one pass. A non-negative count shifts left and a negative count shifts right. The left direction reaches up to 31 places and the right direction reaches up to 16 places. Right shifts are either arithmetic or logical, depending on a mode bit. A count outside the span allowed for its direction is clipped to that limit, and a range flag reports the clip.

The count comes from one of three count inputs, chosen by a 2-bit source select:

- an immediate field from the instruction word;
- a count field held in a mode register;
- the low bits of a temporary register.

A fourth select code forces a zero count.

The shifted word can be registered, which gives one cycle of latency and a valid strobe. It can also be passed straight through as a combinational result. The block sits between operand storage and the arithmetic unit. It holds no operand storage of its own.

Top module: `span_shifter`

## Requirements
- R1: The count source select uses code 0 for the immediate count, 1 for the mode-register count and 2 for the temporary-register count. Code 3 forces a zero count, so the result equals the operand and the range flag stays low.
- R2: A count n from 0 to 31 shifts the 40-bit operand left by n places. Zeros enter at bit 0, and bits moved beyond bit 39 are lost.
- R3: A count of -1 to -16 shifts right by the magnitude. When arith_rs is 1, copies of bit 39 enter at the top. When arith_rs is 0, zeros enter at the top.
- R4: Counts are 6-bit two's complement. A count from -17 to -32 is clipped to a right shift of 16 and sets range_err to 1. Every legal count gives range_err 0.
- R5: With PIPELINE=1, result, range_err and out_valid are updated one clock after an accepted input. out_valid follows in_valid with that one-cycle delay. While in_valid is 0, result and range_err keep their last values.
- R6: With PIPELINE=0, result and range_err follow the inputs in the same cycle, and out_valid equals in_valid.
- R7: While rst_n is low, out_valid, result and range_err are 0. They are cleared at once, without waiting for a clock.
- R8: The two count inputs that are not selected have no effect on result or range_err.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid | input | 1 | Operand and count inputs are valid this cycle |
| operand | input | 40 | Word to be shifted |
| cnt_src | input | 2 | Count source: 0 immediate, 1 mode register, 2 temporary register, 3 zero |
| imm_cnt | input | 6 | Signed count from the instruction immediate |
| mode_cnt | input | 6 | Signed count from the mode-register field |
| treg_cnt | input | 6 | Signed count from the temporary register |
| arith_rs | input | 1 | 1 selects arithmetic right shifts, 0 selects logical right shifts |
| result | output | 40 | Shifted word |
| out_valid | output | 1 | result and range_err are valid |
| range_err | output | 1 | The requested count was clipped |

## Verification
The bench builds two copies of the block with the default width and limits: one with PIPELINE=1 and one with PIPELINE=0. Both copies receive the same stimulus. The registered copy covers the one-cycle latency, the hold behaviour while idle, and the effect of reset on live outputs. The combinational copy is checked in the same cycle as its inputs, so both output variants are compared against one reference model. The default limits of 31 left and 16 right leave the 6-bit range open for clipping in the right direction only. The stimulus therefore covers both full-span shifts and clipped counts down to -32.

// File: rtl/span_pkg.sv
package span_pkg;

  typedef enum logic [1:0] {
    CSRC_IMM  = 2'd0,
    CSRC_MODE = 2'd1,
    CSRC_TREG = 2'd2,
    CSRC_ZERO = 2'd3
  } cnt_src_e;

endpackage

// File: rtl/span_count_sel.sv
module span_count_sel
  import span_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  cnt_src_e           src,
  input  logic [CNT_W-1:0]   imm_cnt,
  input  logic [CNT_W-1:0]   mode_cnt,
  input  logic [CNT_W-1:0]   treg_cnt,
  output logic [CNT_W-1:0]   cnt
);

  always_comb begin
    unique case (src)
      CSRC_IMM:  cnt = imm_cnt;
      CSRC_MODE: cnt = mode_cnt;
      CSRC_TREG: cnt = treg_cnt;
      default:   cnt = '0;
    endcase
  end

endmodule

// File: rtl/span_count_clamp.sv
module span_count_clamp #(
  parameter int CNT_W     = 6,
  parameter int LEFT_MAX  = 31,
  parameter int RIGHT_MAX = 16,
  parameter int AMT_W     = 5
) (
  input  logic [CNT_W-1:0] cnt,
  output logic             go_right,
  output logic [AMT_W-1:0] amt,
  output logic             clipped
);

  localparam logic [CNT_W:0] LMAX = (CNT_W+1)'(LEFT_MAX);
  localparam logic [CNT_W:0] RMAX = (CNT_W+1)'(RIGHT_MAX);

  logic [CNT_W:0] sval;
  logic [CNT_W:0] mag;
  logic [CNT_W:0] lim;
  logic [CNT_W:0] sat;

  always_comb begin
    sval     = {cnt[CNT_W-1], cnt};
    go_right = sval[CNT_W];
    mag      = go_right ? (~sval + 1'b1) : sval;
    lim      = go_right ? RMAX : LMAX;
    clipped  = (mag > lim);
    sat      = clipped ? lim : mag;
    amt      = AMT_W'(sat);
  end

endmodule

// File: rtl/span_shift_core.sv
module span_shift_core #(
  parameter int DATA_W = 40,
  parameter int AMT_W  = 5
) (
  input  logic [DATA_W-1:0] data,
  input  logic              go_right,
  input  logic [AMT_W-1:0]  amt,
  input  logic              arith,
  output logic [DATA_W-1:0] res
);

  logic              fill;
  logic [DATA_W-1:0] lstage [AMT_W+1];
  logic [DATA_W-1:0] rstage [AMT_W+1];

  assign fill      = arith & data[DATA_W-1];
  assign lstage[0] = data;
  assign rstage[0] = data;

  for (genvar k = 0; k < AMT_W; k++) begin : g_stage
    localparam int S = 1 << k;
    assign lstage[k+1] = amt[k] ? {lstage[k][DATA_W-1-S:0], {S{1'b0}}} : lstage[k];
    assign rstage[k+1] = amt[k] ? {{S{fill}}, rstage[k][DATA_W-1:S]}   : rstage[k];
  end

  assign res = go_right ? rstage[AMT_W] : lstage[AMT_W];

endmodule

// File: rtl/span_shifter.sv
module span_shifter
  import span_pkg::*;
#(
  parameter int DATA_W    = 40,
  parameter int CNT_W     = 6,
  parameter int LEFT_MAX  = 31,
  parameter int RIGHT_MAX = 16,
  parameter bit PIPELINE  = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] operand,
  input  logic [1:0]        cnt_src,
  input  logic [CNT_W-1:0]  imm_cnt,
  input  logic [CNT_W-1:0]  mode_cnt,
  input  logic [CNT_W-1:0]  treg_cnt,
  input  logic              arith_rs,
  output logic [DATA_W-1:0] result,
  output logic              out_valid,
  output logic              range_err
);

  localparam int MAX_SPAN = (LEFT_MAX > RIGHT_MAX) ? LEFT_MAX : RIGHT_MAX;
  localparam int AMT_W    = $clog2(MAX_SPAN + 1);

  // reset: asserted asynchronously, released after two clock edges
  logic rst_meta_n, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  cnt_src_e          src;
  logic [CNT_W-1:0]  cnt;
  logic              go_right;
  logic [AMT_W-1:0]  amt;
  logic              clipped;
  logic [DATA_W-1:0] shifted;

  assign src = cnt_src_e'(cnt_src);

  span_count_sel #(.CNT_W(CNT_W)) u_sel (
    .src      (src),
    .imm_cnt  (imm_cnt),
    .mode_cnt (mode_cnt),
    .treg_cnt (treg_cnt),
    .cnt      (cnt)
  );

  span_count_clamp #(
    .CNT_W(CNT_W), .LEFT_MAX(LEFT_MAX), .RIGHT_MAX(RIGHT_MAX), .AMT_W(AMT_W)
  ) u_clamp (
    .cnt      (cnt),
    .go_right (go_right),
    .amt      (amt),
    .clipped  (clipped)
  );

  span_shift_core #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_core (
    .data     (operand),
    .go_right (go_right),
    .amt      (amt),
    .arith    (arith_rs),
    .res      (shifted)
  );

  if (PIPELINE) begin : g_reg
    logic [DATA_W-1:0] res_q, res_d;
    logic              err_q, err_d;
    logic              vld_q, vld_d;

    always_comb begin
      res_d = res_q;
      err_d = err_q;
      vld_d = in_valid;
      if (in_valid) begin
        res_d = shifted;
        err_d = clipped;
      end
    end

    always_ff @(posedge clk or negedge rst_sync_n) begin
      if (!rst_sync_n) begin
        res_q <= '0;
        err_q <= 1'b0;
        vld_q <= 1'b0;
      end else begin
        vld_q <= vld_d;
        if (in_valid) begin
          res_q <= res_d;
          err_q <= err_d;
        end
      end
    end

    assign result    = res_q;
    assign range_err = err_q;
    assign out_valid = vld_q;

    p_valid_lat_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
      in_valid |=> out_valid);
    p_valid_idle_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
      !in_valid |=> !out_valid);
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
      !in_valid |=> ($stable(result) && $stable(range_err)));
    p_zero_src_r1: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (in_valid && cnt_src == 2'd3) |=> (result == $past(operand) && !range_err));
    p_clip_flag_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (in_valid && cnt_src == 2'd0 && (int'($signed(imm_cnt)) < -RIGHT_MAX)) |=> range_err);
    p_logic_fill_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (in_valid && cnt_src == 2'd0 && imm_cnt[CNT_W-1] && !arith_rs) |=> !result[DATA_W-1]);
    p_left_zero_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (in_valid && cnt_src == 2'd0 && !imm_cnt[CNT_W-1] && imm_cnt != '0) |=> !result[0]);
  end else begin : g_comb
    assign result    = shifted;
    assign range_err = clipped;
    assign out_valid = in_valid;

    p_comb_zero_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (cnt_src == 2'd3) |-> (result == operand && !range_err));
    p_comb_fill_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (cnt_src == 2'd0 && imm_cnt[CNT_W-1] && !arith_rs) |-> !result[DATA_W-1]);
  end

endmodule

// File: tb/tb_span_shifter.sv
module tb_span_shifter;

  localparam int  DW         = 40;
  localparam int  CW         = 6;
  localparam time CLK_PERIOD = 10ns;
  localparam int  NVEC       = 12;

  // {operand, cnt_src, count, arith_rs}
  localparam logic [DW+2+CW:0] VEC [NVEC] = '{
    {40'h00_0000_0001, 2'd0, 6'd31,  1'b0},
    {40'hFF_FFFF_FFFF, 2'd0, 6'd4,   1'b0},
    {40'h80_0000_0000, 2'd1, 6'h30,  1'b1},
    {40'h80_0000_0000, 2'd1, 6'h30,  1'b0},
    {40'h12_3456_789A, 2'd2, 6'h3C,  1'b0},
    {40'h80_0000_0000, 2'd0, 6'h20,  1'b1},
    {40'hA5_A5A5_A5A5, 2'd3, 6'h25,  1'b1},
    {40'h7F_FFFF_FFFF, 2'd1, 6'h2F,  1'b1},
    {40'h00_0000_0003, 2'd2, 6'd0,   1'b0},
    {40'hC0_0000_0000, 2'd0, 6'd1,   1'b1},
    {40'h00_0000_FFFF, 2'd1, 6'd24,  1'b0},
    {40'h81_0000_0000, 2'd2, 6'h3F,  1'b1}
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid;
  logic [DW-1:0] operand;
  logic [1:0]    cnt_src;
  logic [CW-1:0] imm_cnt, mode_cnt, treg_cnt;
  logic          arith_rs;
  logic [DW-1:0] result, result_c;
  logic          out_valid, out_valid_c, range_err, range_err_c;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  span_shifter #(.PIPELINE(1'b1)) dut (
    .clk, .rst_n, .in_valid, .operand, .cnt_src, .imm_cnt, .mode_cnt,
    .treg_cnt, .arith_rs, .result, .out_valid, .range_err
  );

  span_shifter #(.PIPELINE(1'b0)) dut_comb (
    .clk, .rst_n, .in_valid, .operand, .cnt_src, .imm_cnt, .mode_cnt,
    .treg_cnt, .arith_rs, .result(result_c), .out_valid(out_valid_c),
    .range_err(range_err_c)
  );

  function automatic logic [DW-1:0] ref_res(logic [DW-1:0] op, logic [1:0] sel,
                                            logic [CW-1:0] c, logic ar);
    int n, m;
    if (sel == 2'd3) return op;
    n = int'($signed(c));
    if (n >= 0) return op << n;
    m = -n;
    if (m > 16) m = 16;
    if (ar) return DW'($signed(op) >>> m);
    return op >> m;
  endfunction

  function automatic logic ref_err(logic [1:0] sel, logic [CW-1:0] c);
    return (sel != 2'd3) && (int'($signed(c)) < -16);
  endfunction

  task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(logic v, logic [DW-1:0] op, logic [1:0] sel, logic [CW-1:0] c,
                       logic ar);
    in_valid = v;
    operand  = op;
    cnt_src  = sel;
    arith_rs = ar;
    imm_cnt  = (sel == 2'd0 || sel == 2'd3) ? c : (c ^ 6'h15);
    mode_cnt = (sel == 2'd1) ? c : (c ^ 6'h2A);
    treg_cnt = (sel == 2'd2) ? c : (c ^ 6'h33);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [DW-1:0] exp_r, last_r;
    logic          exp_e;
    string         tag;

    rst_n = 1'b0;
    drive(1'b0, '0, 2'd0, '0, 1'b0);
    repeat (3) @(negedge clk);
    // R7: reset state
    check("R7 out_valid", DW'(out_valid), '0);
    check("R7 result",    result,         '0);
    check("R7 range_err", DW'(range_err), '0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      logic [DW-1:0] op;
      logic [1:0]    sel;
      logic [CW-1:0] c;
      logic          ar;
      {op, sel, c, ar} = VEC[i];
      exp_r = ref_res(op, sel, c, ar);
      exp_e = ref_err(sel, c);
      tag = (sel == 2'd3) ? "R1" : ($signed(c) < 0 ? "R3" : "R2");
      drive(1'b1, op, sel, c, ar);
      #1;
      check({tag, " R6 comb result"}, result_c, exp_r);
      check("R6 comb valid", DW'(out_valid_c), 1);
      check("R4 R6 comb range_err", DW'(range_err_c), DW'(exp_e));
      @(negedge clk);
      check({tag, " R8 result"}, result, exp_r);
      check("R4 range_err", DW'(range_err), DW'(exp_e));
      check("R5 out_valid", DW'(out_valid), 1);
      last_r = exp_r;
    end

    // R5: idle cycle keeps the last result and drops valid
    drive(1'b0, 40'h55_5555_5555, 2'd0, 6'd3, 1'b0);
    @(negedge clk);
    check("R5 idle valid", DW'(out_valid), '0);
    check("R5 idle hold",  result, last_r);

    // R8: unselected count inputs changed, selected one fixed at 2
    drive(1'b1, 40'h00_0000_0101, 2'd0, 6'd2, 1'b0);
    mode_cnt = 6'h21;
    treg_cnt = 6'h1F;
    @(negedge clk);
    check("R8 unselected counts", result, 40'h00_0000_0404);
    check("R8 unselected err", DW'(range_err), '0);

    // R4: most negative count, arithmetic, clipped to 16
    drive(1'b1, 40'hF0_0000_0000, 2'd2, 6'h20, 1'b1);
    @(negedge clk);
    check("R4 clip -32", result, 40'hFF_FFF0_0000);
    check("R4 clip flag", DW'(range_err), 1);

    // R7: asynchronous clear of live outputs
    drive(1'b0, '0, 2'd0, '0, 1'b0);
    #2;
    rst_n = 1'b0;
    #1;
    check("R7 async result", result, '0);
    check("R7 async valid",  DW'(out_valid), '0);
    check("R7 async err",    DW'(range_err), '0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    finish_run();
  end

endmodule